// File: doc/BRIEF.md
# Unimplemented Opcode Trap Dispatcher

This block sits beside the instruction decoder and sorts each decoded 9-bit opcode into one of four outcomes. The instruction may execute normally. It may be trapped to a handler in the user's own space. It may be trapped to a monitor handler in executive space. Or it may be dropped as a no-operation. The decision depends on the opcode range and on the current processor mode. For every trap, the block produces a pair of vector addresses: an even store location and the execute location just above it. It also produces an address-space select that tells the memory stage which space the pair lives in.

A trap-offset enable moves every executive vector up by 0100 (octal), so that the executive pairs sit at 140/141 and 160/161 instead of 40/41 and 60/61. The user pair never moves. A 64-bit table input marks which opcodes in the 100–177 range the core implements. An implemented opcode in that range passes through, and an unimplemented one traps to the monitor. Saving the trapped instruction and performing the memory writes belong to the stages downstream.

The opcode side is a one-way strobe with no back-pressure. There is no ready signal, so every cycle with `instr_valid` high is taken. The result appears on the registered outputs one cycle later and stays there until the next strobe.

Top module: `trap_dispatch`

## Requirements
- R1: While `rst_n` is low, `trap_req`, `nop_flag`, `space_sel`, `store_vec` and `exec_vec` are all 0.
- R2: Opcode 000, and opcodes 040 through 077, trap to executive space (`space_sel`=0) with `store_vec` = 040, whatever the mode.
- R3: Opcodes 001 through 037 in user mode (`user_mode`=1) trap to user space (`space_sel`=1) with `store_vec` = 040.
- R4: Opcodes 001 through 037 in executive mode (`user_mode`=0) trap to executive space with `store_vec` = 040.
- R5: An opcode from 100 through 177 whose table bit `impl_map[opcode-0100]` is 0 traps to executive space with `store_vec` = 060.
- R6: An opcode from 100 through 177 whose table bit is 1 executes normally: `trap_req`=0, `nop_flag`=0, and both vectors and `space_sel` are 0.
- R7: Opcode 257 gives `nop_flag`=1 and `trap_req`=0, with both vectors 0. `trap_req` and `nop_flag` are never high together.
- R8: With `trap_offset_en`=1 at the strobe, every executive vector gains 0100 (040 becomes 140 and 060 becomes 160). The user vector stays at 040.
- R9: The outputs change only on the clock edge where `instr_valid` is sampled high. They take that strobe's result and hold it through every cycle without a strobe.
- R10: Whenever `trap_req` is 1, `store_vec` is even and `exec_vec` equals `store_vec`+1.
- R11: Every other opcode (200 through 777 except 257) executes normally, with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Opcode strobe, taken every cycle it is high |
| opcode | input | 9 | Opcode of the instruction being decoded |
| user_mode | input | 1 | 1 = processor in user mode, 0 = executive mode |
| trap_offset_en | input | 1 | 1 = executive vectors relocated up by 0100 |
| impl_map | input | 64 | Bit i = 1 marks opcode 0100+i as implemented |
| trap_req | output | 1 | Registered trap request |
| store_vec | output | 18 | Store location of the trap pair (even) |
| exec_vec | output | 18 | Execute location of the trap pair |
| space_sel | output | 1 | 1 = user space, 0 = executive space |
| nop_flag | output | 1 | Instruction is suppressed as a no-operation |

## Verification
The bench goes after the edges of each opcode range: 000 against 001, 037 against 040, 077 against 100, 177 against 200, and 257 against its neighbours 256 and 260. A design with an off-by-one range would send one of these to the wrong pair, or drop a trap entirely. It mixes the mode bit and the offset bit on the user range. A design that relocated the user pair, or ignored the mode, would show up as a wrong vector or a wrong space select. It also pulses the implemented table, and changes the inputs during idle cycles. This catches a table indexed from the wrong base, and an output stage that follows the inputs without a strobe.

// File: rtl/trapdisp_pkg.sv
package trapdisp_pkg;

  // Outcome of decoding one opcode.
  typedef enum logic [2:0] {
    ACT_PASS      = 3'd0,
    ACT_NOP       = 3'd1,
    ACT_USER_TRAP = 3'd2,
    ACT_MON_UUO   = 3'd3,
    ACT_MON_UNIMP = 3'd4
  } act_t;

endpackage

// File: rtl/trapdisp_classify.sv
module trapdisp_classify
  import trapdisp_pkg::*;
#(
  parameter int OP_W      = 9,
  parameter int USER_HI   = 31,   // last user-handled code (037)
  parameter int MON_LO    = 32,   // 040
  parameter int MON_HI    = 63,   // 077
  parameter int TABLE_LO  = 64,   // 100
  parameter int TABLE_CNT = 64,   // 100..177
  parameter int NOP_CODE  = 175   // 257
) (
  input  logic [OP_W-1:0]      op,
  input  logic                 user_mode,
  input  logic [TABLE_CNT-1:0] impl_map,
  output act_t                 act
);

  localparam logic [OP_W-1:0] USER_HI_C = OP_W'(USER_HI);
  localparam logic [OP_W-1:0] MON_LO_C  = OP_W'(MON_LO);
  localparam logic [OP_W-1:0] MON_HI_C  = OP_W'(MON_HI);
  localparam logic [OP_W-1:0] NOP_C     = OP_W'(NOP_CODE);

  logic                 is_zero;
  logic                 mon_range;
  logic                 user_range;
  logic [TABLE_CNT-1:0] miss;
  logic                 unimpl;

  assign is_zero    = (op == '0);
  assign mon_range  = is_zero || ((op >= MON_LO_C) && (op <= MON_HI_C));
  assign user_range = !is_zero && (op <= USER_HI_C);

  // One comparator per table entry: hit on this code with the bit clear.
  for (genvar i = 0; i < TABLE_CNT; i++) begin : g_table
    localparam logic [OP_W-1:0] CODE = OP_W'(TABLE_LO + i);
    assign miss[i] = (op == CODE) && !impl_map[i];
  end

  assign unimpl = |miss;

  always_comb begin
    act = ACT_PASS;
    if (mon_range)       act = ACT_MON_UUO;
    else if (user_range) act = user_mode ? ACT_USER_TRAP : ACT_MON_UUO;
    else if (unimpl)     act = ACT_MON_UNIMP;
    else if (op == NOP_C) act = ACT_NOP;
  end

endmodule

// File: rtl/trapdisp_vector.sv
module trapdisp_vector
  import trapdisp_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int UUO_BASE    = 32,  // 040
  parameter int UNIMP_BASE  = 48,  // 060
  parameter int EXEC_SHIFT  = 64   // 0100
) (
  input  act_t              act,
  input  logic              offset_en,
  output logic              trap,
  output logic              nop,
  output logic              user_sp,
  output logic [ADDR_W-1:0] store,
  output logic [ADDR_W-1:0] exec
);

  localparam logic [ADDR_W-1:0] UUO_C   = ADDR_W'(UUO_BASE);
  localparam logic [ADDR_W-1:0] UNIMP_C = ADDR_W'(UNIMP_BASE);
  localparam logic [ADDR_W-1:0] SHIFT_C = ADDR_W'(EXEC_SHIFT);

  logic [ADDR_W-1:0] shift;
  assign shift = offset_en ? SHIFT_C : '0;

  always_comb begin
    trap    = 1'b0;
    nop     = 1'b0;
    user_sp = 1'b0;
    store   = '0;
    unique case (act)
      ACT_USER_TRAP: begin trap = 1'b1; user_sp = 1'b1; store = UUO_C; end
      ACT_MON_UUO:   begin trap = 1'b1; store = UUO_C + shift; end
      ACT_MON_UNIMP: begin trap = 1'b1; store = UNIMP_C + shift; end
      ACT_NOP:       nop = 1'b1;
      default:       ;
    endcase
  end

  // Execute location sits directly above the even store location.
  assign exec = trap ? {store[ADDR_W-1:1], 1'b1} : '0;

endmodule

// File: rtl/trapdisp_hold.sv
module trapdisp_hold #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              trap_d,
  input  logic              nop_d,
  input  logic              user_d,
  input  logic [ADDR_W-1:0] store_d,
  input  logic [ADDR_W-1:0] exec_d,
  output logic              trap_q,
  output logic              nop_q,
  output logic              user_q,
  output logic [ADDR_W-1:0] store_q,
  output logic [ADDR_W-1:0] exec_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      nop_q   <= 1'b0;
      user_q  <= 1'b0;
      store_q <= '0;
      exec_q  <= '0;
    end else if (load) begin
      trap_q  <= trap_d;
      nop_q   <= nop_d;
      user_q  <= user_d;
      store_q <= store_d;
      exec_q  <= exec_d;
    end
  end

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trapdisp_pkg::*;
#(
  parameter int OP_W      = 9,
  parameter int ADDR_W    = 18,
  parameter int TABLE_LO  = 64,
  parameter int TABLE_CNT = 64,
  parameter int NOP_CODE  = 175,
  parameter int EXEC_SHIFT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [OP_W-1:0]      opcode,
  input  logic                 user_mode,
  input  logic                 trap_offset_en,
  input  logic [TABLE_CNT-1:0] impl_map,
  output logic                 trap_req,
  output logic [ADDR_W-1:0]    store_vec,
  output logic [ADDR_W-1:0]    exec_vec,
  output logic                 space_sel,
  output logic                 nop_flag
);

  act_t              act;
  logic              trap_d, nop_d, user_d;
  logic [ADDR_W-1:0] store_d, exec_d;

  trapdisp_classify #(
    .OP_W(OP_W), .TABLE_LO(TABLE_LO), .TABLE_CNT(TABLE_CNT), .NOP_CODE(NOP_CODE)
  ) u_cls (
    .op(opcode), .user_mode(user_mode), .impl_map(impl_map), .act(act)
  );

  trapdisp_vector #(
    .ADDR_W(ADDR_W), .EXEC_SHIFT(EXEC_SHIFT)
  ) u_vec (
    .act(act), .offset_en(trap_offset_en), .trap(trap_d), .nop(nop_d),
    .user_sp(user_d), .store(store_d), .exec(exec_d)
  );

  trapdisp_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(instr_valid),
    .trap_d(trap_d), .nop_d(nop_d), .user_d(user_d), .store_d(store_d), .exec_d(exec_d),
    .trap_q(trap_req), .nop_q(nop_flag), .user_q(space_sel),
    .store_q(store_vec), .exec_q(exec_vec)
  );

endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [8:0]        opcode,
  input logic              user_mode,
  input logic              trap_offset_en,
  input logic [63:0]       impl_map,
  input logic              trap_req,
  input logic [ADDR_W-1:0] store_vec,
  input logic [ADDR_W-1:0] exec_vec,
  input logic              space_sel,
  input logic              nop_flag
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(trap_req) && $stable(store_vec) && $stable(exec_vec)
                      && $stable(space_sel) && $stable(nop_flag)));

  p_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!store_vec[0] && exec_vec == store_vec + 1'b1));

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && nop_flag));

  p_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode == 9'o257) |=> (nop_flag && !trap_req));

  p_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && user_mode && opcode != 9'o000 && opcode <= 9'o037)
      |=> (trap_req && space_sel && store_vec == ADDR_W'(32)));

  p_unimpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode[8:6] == 3'o1 && !impl_map[opcode[5:0]])
      |=> (trap_req && !space_sel
           && store_vec == ($past(trap_offset_en) ? ADDR_W'(112) : ADDR_W'(48))));

  p_user_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    space_sel |-> (trap_req && store_vec == ADDR_W'(32)));

endmodule

bind trap_dispatch trap_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
  .user_mode(user_mode), .trap_offset_en(trap_offset_en), .impl_map(impl_map),
  .trap_req(trap_req), .store_vec(store_vec), .exec_vec(exec_vec),
  .space_sel(space_sel), .nop_flag(nop_flag)
);

// File: tb/sim_trap_dispatch.sv
`timescale 1ns/1ps
module sim_trap_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [8:0]  opcode = '0;
  logic        user_mode = 1'b0;
  logic        trap_offset_en = 1'b0;
  logic [63:0] impl_map = '0;
  logic        trap_req, space_sel, nop_flag;
  logic [17:0] store_vec, exec_vec;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  // Reference state (what the outputs should show).
  bit ex_trap = 0, ex_nop = 0, ex_user = 0;
  int ex_store = 0;

  always #2.5 clk = ~clk;

  trap_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .user_mode(user_mode), .trap_offset_en(trap_offset_en), .impl_map(impl_map),
    .trap_req(trap_req), .store_vec(store_vec), .exec_vec(exec_vec),
    .space_sel(space_sel), .nop_flag(nop_flag)
  );

  // Behavioural model of the dispatch rules.
  task automatic model(input int op, input bit usr, input bit off, input logic [63:0] map,
                       output bit t, output bit n, output bit u, output int s);
    int shift = off ? 64 : 0;
    t = 0; n = 0; u = 0; s = 0;
    if (op == 0 || (op >= 32 && op <= 63)) begin t = 1; s = 32 + shift; end
    else if (op <= 31) begin
      t = 1;
      if (usr) begin u = 1; s = 32; end else s = 32 + shift;
    end else if (op >= 64 && op <= 127) begin
      if (!map[op - 64]) begin t = 1; s = 48 + shift; end
    end else if (op == 175) n = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ex_trap = 0; ex_nop = 0; ex_user = 0; ex_store = 0;
    end else if (instr_valid) begin
      model(int'(opcode), user_mode, trap_offset_en, impl_map, ex_trap, ex_nop, ex_user, ex_store);
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      int ex_exec;
      ex_exec = ex_trap ? ex_store + 1 : 0;
      tests++;
      if (trap_req !== ex_trap || nop_flag !== ex_nop || space_sel !== ex_user ||
          int'(store_vec) != ex_store || int'(exec_vec) != ex_exec) begin
        fails++;
        $display("FAIL %s: got trap=%0b nop=%0b usr=%0b st=%0o ex=%0o, expected trap=%0b nop=%0b usr=%0b st=%0o ex=%0o",
                 cur_tag, trap_req, nop_flag, space_sel, store_vec, exec_vec,
                 ex_trap, ex_nop, ex_user, ex_store, ex_exec);
      end
    end
  end

  task automatic drive(input bit v, input int op, input bit usr, input bit off, input string tag);
    @(negedge clk);
    #1;
    instr_valid = v; opcode = 9'(op); user_mode = usr; trap_offset_en = off; cur_tag = tag;
  endtask

  initial begin
    impl_map = 64'h0000_0000_FFFF_0000;
    // R1: reset state, checked at each negedge while reset is low
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;

    // R2: 000 and 040..077 in both modes, offset off then on
    drive(1, 0, 1, 0, "R2"); drive(1, 8'o40, 1, 0, "R2"); drive(1, 8'o77, 0, 0, "R2");
    drive(1, 0, 0, 1, "R8"); drive(1, 8'o40, 1, 1, "R8"); drive(1, 8'o77, 1, 1, "R8");
    // R3 / R4: user range at both edges, both modes, offset both ways
    drive(1, 1, 1, 0, "R3"); drive(1, 8'o37, 1, 1, "R3");
    drive(1, 1, 0, 0, "R4"); drive(1, 8'o37, 0, 1, "R4");
    // R5 / R6: table range edges and map bits
    drive(1, 8'o100, 0, 0, "R5"); drive(1, 8'o177, 1, 1, "R5");
    drive(1, 8'o120, 1, 0, "R6"); drive(1, 8'o137, 0, 1, "R6");
    // R7 and neighbours (R11)
    drive(1, 9'o257, 1, 1, "R7"); drive(1, 9'o256, 0, 0, "R11");
    drive(1, 9'o260, 0, 0, "R11"); drive(1, 9'o200, 1, 1, "R11"); drive(1, 9'o777, 0, 0, "R11");
    // R9: hold through idle cycles with changing inputs
    drive(1, 8'o40, 0, 1, "R9");
    drive(0, 9'o257, 1, 0, "R9"); drive(0, 0, 1, 0, "R9"); drive(0, 8'o100, 0, 0, "R9");
    // R10: pair check on every trap above; random sweep
    for (int i = 0; i < 3000; i++) begin
      int op;
      if (i % 97 == 0) impl_map = {$urandom, $urandom};
      case ($urandom % 5)
        0: op = $urandom % 512;
        1: op = 175;
        default: op = $urandom % 192;
      endcase
      drive(($urandom % 4) != 0, op, $urandom % 2, $urandom % 2, "R10");
    end
    drive(0, 0, 0, 0, "R9");
    @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule